// File: doc/BRIEF.md
# Serial Interrupt Line Peripheral Agent

This block is the device-side agent on a single shared, open-drain interrupt line that several devices and one host controller serialize their interrupt requests over. Everything runs on the rising edge of the bus clock. The agent detects the host's start frame, counts the fixed number of three-clock request frames that follow, and pulls the line low in the frames assigned to its requesting sources. One frame is reserved for a system-management request. Each frame has a sample clock, a recovery clock and a turnaround clock. In the sample clock a requesting agent drives low. In the recovery clock it drives high for one clock. In the turnaround clock the line is released.

The host closes every cycle with a stop pulse. The agent measures the low width of that pulse. A two-clock pulse puts the next cycle into quiet mode, and in quiet mode the agent may open a cycle on its own with a one-clock low pulse when it has something pending. A three-clock pulse keeps the line in continuous mode, where only the host starts cycles. The system-management request can also drive a separate active-low pin, and that path has its own enable.

Top module: `serirq_agent`

## Requirements
- R1: While `rst_n` is low, `sirq_oe` is 0. After reset the agent is in continuous mode, so a pending request does not make it drive the line until a quiet stop pulse has been seen.
- R2: The first high clock after a start frame's low pulse is clock r. The sample clock of frame f is clock r+2+3f, and the agent leaves the line released in clock r+1.
- R3: Source i is assigned to the frame held in `irq_slot[i*SLOT_W +: SLOT_W]`. In the sample clock of a frame that is requested, the agent drives low. In the recovery clock it drives high. In the turnaround clock it releases the line. A frame that is not requested is released in all three clocks.
- R4: Several requesting sources on different frames each produce their own frame. Several requests on the same frame produce one single low sample and one high recovery.
- R5: The system-management request uses frame `smi_slot` only while `smi_frame_en` is 1.
- R6: `smi_pin_n` is 0 exactly when `smi_req` and `smi_pin_en` are both 1, whatever the value of `smi_frame_en`.
- R7: A stop pulse that is low for two clocks selects quiet mode. A stop pulse that is low for three clocks selects continuous mode.
- R8: In quiet mode with a request pending, the agent drives a one-clock low pulse in clock r'+2, where r' is the first high clock after the stop pulse. The line stays released in clock r'+1, and the agent releases it again in the clock after the pulse.
- R9: In continuous mode, and in quiet mode with nothing pending, the agent never starts a cycle.
- R10: After the last of the `NUM_FRAMES` frames, the agent does not drive the line during the stop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling and driving on its rising edge |
| rst_n | input | 1 | Bus reset, active low, asynchronous assert |
| sirq_in | input | 1 | Sampled level of the shared line |
| sirq_oe | output | 1 | Drive enable for the open-drain pad |
| sirq_out | output | 1 | Level driven while `sirq_oe` is 1 |
| irq_req | input | N_SRC | Interrupt requests, one per source |
| irq_slot | input | N_SRC*SLOT_W | Frame index per source, source i at bits i*SLOT_W |
| smi_req | input | 1 | System-management request |
| smi_slot | input | SLOT_W | Frame index for the system-management request |
| smi_frame_en | input | 1 | Enables reporting of `smi_req` in its serial frame |
| smi_pin_en | input | 1 | Enables reporting of `smi_req` on `smi_pin_n` |
| smi_pin_n | output | 1 | Dedicated system-management output, active low |

## Verification
An interrupt source and the system-management request can be assigned to the same frame, which makes both of them want to drive in the same sample clock. The bench provokes this by mapping source 0 and `smi_slot` to one frame with `smi_frame_en` set. It judges the result by requiring exactly one low sample clock, one high recovery clock and a released turnaround, and it requires every other frame to stay released. A second kind of collision is a quiet-mode self-start that lands in the same cycle sequence as the host's own start frame. The bench checks the agent's one-clock pulse at clock r'+2 and its release one clock later, while the host keeps the line low.

// File: rtl/serirq_agent.sv
module serirq_agent #(
  parameter int N_SRC      = 4,
  parameter int NUM_FRAMES = 8,
  parameter int SLOT_W     = $clog2(NUM_FRAMES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sirq_in,
  output logic                    sirq_oe,
  output logic                    sirq_out,
  input  logic [N_SRC-1:0]        irq_req,
  input  logic [N_SRC*SLOT_W-1:0] irq_slot,
  input  logic                    smi_req,
  input  logic [SLOT_W-1:0]       smi_slot,
  input  logic                    smi_frame_en,
  input  logic                    smi_pin_en,
  output logic                    smi_pin_n
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_LEAD, S_FRAME, S_STOP} st_t;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_FRAMES - 1);

  st_t               st;
  logic [1:0]        ph;
  logic [SLOT_W-1:0] slot, slot_nx;
  logic [1:0]        low_cnt;
  logic              quiet, oe_q, out_q, hit, pending;

  assign sirq_oe   = oe_q;
  assign sirq_out  = out_q;
  assign smi_pin_n = !(smi_req && smi_pin_en);
  assign pending   = (|irq_req) || (smi_req && smi_frame_en);
  assign slot_nx   = (st == S_LEAD) ? '0 : slot + 1'b1;

  always_comb begin
    hit = smi_req && smi_frame_en && (smi_slot == slot_nx);
    for (int i = 0; i < N_SRC; i++)
      if (irq_req[i] && irq_slot[i*SLOT_W +: SLOT_W] == slot_nx) hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 2'd0; slot <= '0; low_cnt <= 2'd0;
      quiet <= 1'b0; oe_q <= 1'b0; out_q <= 1'b1;
    end else begin
      oe_q  <= 1'b0;
      out_q <= 1'b1;
      case (st)
        S_IDLE:
          if (!sirq_in) st <= S_START;
          else if (quiet && pending) begin
            oe_q <= 1'b1; out_q <= 1'b0; st <= S_START;
          end
        S_START:
          if (sirq_in) st <= S_LEAD;
        S_LEAD: begin
          st <= S_FRAME; ph <= 2'd0; slot <= slot_nx;
          oe_q <= hit; out_q <= 1'b0;
        end
        S_FRAME:
          case (ph)
            2'd0: begin
              ph <= 2'd1;
              if (oe_q && !out_q) oe_q <= 1'b1;
            end
            2'd1: ph <= 2'd2;
            default:
              if (slot == LAST) begin
                st <= S_STOP; low_cnt <= 2'd0;
              end else begin
                ph <= 2'd0; slot <= slot_nx;
                oe_q <= hit; out_q <= 1'b0;
              end
          endcase
        S_STOP:
          if (!sirq_in) low_cnt <= (low_cnt == 2'd3) ? 2'd3 : low_cnt + 2'd1;
          else if (low_cnt != 2'd0) begin
            quiet <= (low_cnt == 2'd2);
            st    <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serirq_agent_chk.sv
module serirq_agent_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sirq_in,
  input logic       sirq_oe,
  input logic       sirq_out,
  input logic [2:0] st,
  input logic [1:0] ph,
  input logic [1:0] low_cnt,
  input logic       quiet
);
  assert_released_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !sirq_oe);

  assert_recovery_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && !sirq_out && st == 3'd3 && ph == 2'd0) |=> (sirq_oe && sirq_out));

  assert_high_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && sirq_out) |=> !sirq_oe);

  assert_stop_two_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && sirq_in && low_cnt == 2'd2) |=> quiet);

  assert_stop_three_cont_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && sirq_in && low_cnt == 2'd3) |=> !quiet);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && sirq_oe) |=> !sirq_oe);

  assert_no_start_cont_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && !quiet) |=> !sirq_oe);

  assert_quiet_in_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4) |-> !sirq_oe);
endmodule

bind serirq_agent serirq_agent_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sirq_in(sirq_in), .sirq_oe(sirq_oe),
  .sirq_out(sirq_out), .st(st), .ph(ph), .low_cnt(low_cnt), .quiet(quiet)
);

// File: tb/serirq_agent_tb.sv
module serirq_agent_tb_top;
  localparam int NS = 4, NF = 8, SW = 3;

  logic clk = 1'b0, rst_n = 1'b0, host_low = 1'b0;
  logic [NS-1:0]    irq_req = '0;
  logic [NS*SW-1:0] irq_slot = '0;
  logic             smi_req = 1'b0, smi_fe = 1'b0, smi_pe = 1'b0;
  logic [SW-1:0]    smi_slot = '0;
  logic             sirq_oe, sirq_out, smi_pin_n, line;
  int  errs = 0, checks = 0;
  bit  quiet_exp = 1'b0, done = 1'b0;

  always #10 clk = ~clk;
  assign line = host_low ? 1'b0 : (sirq_oe ? sirq_out : 1'b1);

  serirq_agent #(.N_SRC(NS), .NUM_FRAMES(NF), .SLOT_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sirq_in(line), .sirq_oe(sirq_oe), .sirq_out(sirq_out),
    .irq_req(irq_req), .irq_slot(irq_slot), .smi_req(smi_req), .smi_slot(smi_slot),
    .smi_frame_en(smi_fe), .smi_pin_en(smi_pe), .smi_pin_n(smi_pin_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NF-1:0] expect_frames();
    logic [NF-1:0] e = '0;
    for (int i = 0; i < NS; i++)
      if (irq_req[i]) e[irq_slot[i*SW +: SW]] = 1'b1;
    if (smi_req && smi_fe) e[smi_slot] = 1'b1;
    return e;
  endfunction

  task automatic after_stop(input string tag, output int start_left);
    bit pend = (|irq_req) || (smi_req && smi_fe);
    @(negedge clk);
    chk(!sirq_oe, "R8 holdoff", sirq_oe, 0);
    @(negedge clk);
    if (quiet_exp && pend) begin
      chk(sirq_oe && !sirq_out, "R8 self start", {sirq_oe, sirq_out}, 2);
      host_low = 1'b1;
      start_left = 3;
    end else begin
      chk(!sirq_oe, tag, sirq_oe, 0);
      start_left = 4;
    end
  endtask

  task automatic run_cycle(input int start_left, input int stop_w);
    logic [NF-1:0] e = expect_frames();
    for (int k = 0; k < start_left; k++) begin
      @(negedge clk);
      chk(!sirq_oe, "R8 single pulse", sirq_oe, 0);
      host_low = 1'b1;
    end
    @(negedge clk); host_low = 1'b0;
    @(negedge clk);
    chk(!sirq_oe, "R2 lead turnaround", sirq_oe, 0);
    for (int f = 0; f < NF; f++) begin
      logic [2:0] act, xp;
      @(negedge clk); act[2] = sirq_oe && !sirq_out;
      @(negedge clk); act[1] = sirq_oe && sirq_out;
      @(negedge clk); act[0] = !sirq_oe;
      xp = e[f] ? 3'b111 : 3'b001;
      chk(act == xp, "R3 frame pattern", act, xp);
    end
    for (int k = 0; k < stop_w; k++) begin
      @(negedge clk);
      chk(!sirq_oe, "R10 stop", sirq_oe, 0);
      host_low = 1'b1;
    end
    @(negedge clk); host_low = 1'b0;
    quiet_exp = (stop_w == 2);
  endtask

  task automatic full_cycle(input string tag, input int stop_w);
    int sl;
    after_stop(tag, sl);
    run_cycle(sl, stop_w);
  endtask

  initial begin
    irq_req = 4'b0011;
    repeat (3) @(negedge clk);
    chk(!sirq_oe, "R1 reset release", sirq_oe, 0);
    rst_n = 1'b1;
    full_cycle("R1 continuous after reset", 2);
    // R4 sweep: one source at a time over every frame, modes alternate (R7, R8, R9)
    for (int i = 0; i < NS; i++)
      for (int s = 0; s < NF; s++) begin
        irq_req = '0; irq_req[i] = 1'b1;
        for (int j = 0; j < NS; j++) irq_slot[j*SW +: SW] = SW'((s + 3*j) % NF);
        full_cycle(quiet_exp ? "R8" : "R9 continuous", ((s + i) % 2 == 1) ? 2 : 3);
      end
    // R4 several sources, two sharing frame 5
    irq_req = 4'b1111;
    irq_slot = {3'd5, 3'd5, 3'd2, 3'd7};
    full_cycle("R9", 2);
    // quiet with nothing pending: R9
    irq_req = '0;
    full_cycle("R9 quiet idle", 3);
    // R5, R6: SMI frame and pin enables
    smi_req = 1'b1; smi_slot = 3'd6;
    for (int m = 0; m < 4; m++) begin
      smi_fe = m[0]; smi_pe = m[1];
      #1;
      chk(smi_pin_n == !(m[1]), "R6 smi pin", smi_pin_n, !(m[1]));
      full_cycle("R5 smi gate", 2);
    end
    // R4/R5 collision: source 0 and SMI on frame 4
    smi_fe = 1'b1; smi_slot = 3'd4;
    irq_req = 4'b0001; irq_slot[0 +: SW] = 3'd4;
    full_cycle("R5", 3);
    smi_req = 1'b0; irq_req = '0;
    full_cycle("R9 final", 3);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule